// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block keeps wall-clock time for a low-rate timekeeping subsystem. A one-cycle strobe that arrives once per second advances seconds and minutes in BCD. Hours are kept in BCD in either a 24-hour mode or a 12-hour mode with a PM flag. A 9-bit binary day count advances at midnight. The whole state is presented as one packed 32-bit time word.

Software sets the clock through an initialization level. While that level is high the count is frozen. When it falls, the block captures a complete time word and waits a short, parameterized settling interval before it honours seconds strobes again.

Daylight-saving changes use one-cycle add-hour and subtract-hour pulses, which take effect without entering initialization. A pulse that arrives in the same cycle as a strobe that carries into the hour is held and applied at the next strobe. A sticky flag reports when the day count has passed a programmable threshold, and a gated interrupt output follows that flag.

Top module: `cal_time_core`

## Requirements
- R1: After reset the time word is 0x00000000, and the threshold flag and interrupt are low.
- R2: Time word layout: day in bits 31:23 (binary), PM in bit 22, hour tens 21:20, hour units 19:16, minute tens 14:12, minute units 11:8, second tens 6:4, second units 3:0. Bits 15 and 7 always read 0, even if they were set in the loaded word.
- R3: While `init_i` is high the time word does not change, and seconds strobes and hour commands are ignored.
- R4: In the clock after `init_i` falls, `load_i` is captured as the time. PM is forced to 0 in 24-hour mode. For the next `RESUME_CLKS` clocks (default 3) seconds strobes are ignored.
- R5: Each accepted strobe advances seconds. Seconds roll from 59 to 00 and carry into minutes. Minutes roll from 59 to 00 and carry into the hour.
- R6: With `fmt12_i`=0 (24-hour), the hour runs 00 to 23. Going from 23 to 00 increments the day.
- R7: With `fmt12_i`=1 (12-hour), the hour runs 12, 01 ... 11. PM toggles on the 11 to 12 step. The day increments when 11 PM becomes 12 AM.
- R8: An `add_hr_i` pulse raises the hour by one in a single step, without touching minutes or seconds. Crossing midnight increments the day and keeps PM consistent. If add and subtract pulse together, add wins.
- R9: A `sub_hr_i` pulse lowers the hour by one. It has no effect at hour 00 in 24-hour mode. In 12-hour mode, 12 AM becomes 11 PM of the previous day.
- R10: An hour command that coincides with a strobe that carries into the hour is deferred. It is applied together with the next accepted strobe.
- R11: The day count saturates at 511 when incremented and at 0 when decremented.
- R12: The threshold flag is set when the day exceeds `thresh_i`. It stays set until `thr_clr_i` pulses while the day no longer exceeds the threshold. `thr_irq_o` is the flag gated by `thr_ie_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle seconds strobe |
| init_i | input | 1 | Initialization level; freezes the count, loads on its fall |
| load_i | input | 32 | Time word captured when leaving initialization |
| fmt12_i | input | 1 | Hour mode: 0 = 24-hour, 1 = 12-hour with PM |
| add_hr_i | input | 1 | One-cycle add-one-hour command |
| sub_hr_i | input | 1 | One-cycle subtract-one-hour command |
| thresh_i | input | 9 | Day threshold |
| thr_ie_i | input | 1 | Threshold interrupt enable |
| thr_clr_i | input | 1 | Threshold flag clear strobe |
| time_o | output | 32 | Packed time word |
| thr_flag_o | output | 1 | Sticky day-over-threshold flag |
| thr_irq_o | output | 1 | Gated threshold interrupt |

## Verification
The bench drives the carry chain at its edges: 23:59:59, 11:59:59 AM and PM, 12:59:59 PM, and the saturated day 511. A wrong carry would show as a skipped or repeated hour, a PM bit that toggles at the wrong hour, or a day count that wraps to zero.

Hour commands are tested on each wrap point in both modes, including subtract at 00 in 24-hour mode and at 12 AM in 12-hour mode. A design that underflows the hour there would show 23 or 99.

An add pulse is placed on the exact strobe that carries the hour. A design without deferral would lose the adjustment or apply it twice.

Strobes are also issued inside the post-load settling window and during initialization. The threshold flag is given a clear while its condition still holds, where a naive clear would drop it.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int DAY_W = 9;
    localparam logic [DAY_W-1:0] DAY_MAX = '1;

    typedef enum logic [1:0] {
        HOP_NONE,
        HOP_INC,
        HOP_DEC
    } hour_op_e;

    typedef struct packed {
        logic [DAY_W-1:0] day;
        logic             pm;
        logic [1:0]       hr_t;
        logic [3:0]       hr_u;
        logic [2:0]       mn_t;
        logic [3:0]       mn_u;
        logic [2:0]       sc_t;
        logic [3:0]       sc_u;
    } cal_time_t;

    function automatic logic [31:0] cal_pack(cal_time_t t);
        return {t.day, t.pm, t.hr_t, t.hr_u, 1'b0, t.mn_t, t.mn_u, 1'b0, t.sc_t, t.sc_u};
    endfunction

    function automatic cal_time_t cal_unpack(logic [31:0] w, logic fmt12);
        cal_time_t t;
        t.day  = w[31:23];
        t.pm   = fmt12 & w[22];
        t.hr_t = w[21:20];
        t.hr_u = w[19:16];
        t.mn_t = w[14:12];
        t.mn_u = w[11:8];
        t.sc_t = w[6:4];
        t.sc_u = w[3:0];
        return t;
    endfunction

endpackage

// File: rtl/cal_bcd60.sv
module cal_bcd60 (
    input  logic       inc_i,
    input  logic [2:0] tens_i,
    input  logic [3:0] units_i,
    output logic [2:0] tens_o,
    output logic [3:0] units_o,
    output logic       carry_o
);
    always_comb begin
        tens_o  = tens_i;
        units_o = units_i;
        carry_o = 1'b0;
        if (inc_i) begin
            if (units_i == 4'd9) begin
                units_o = 4'd0;
                if (tens_i == 3'd5) begin
                    tens_o  = 3'd0;
                    carry_o = 1'b1;
                end else begin
                    tens_o = tens_i + 3'd1;
                end
            end else begin
                units_o = units_i + 4'd1;
            end
        end
    end
endmodule

// File: rtl/cal_hour_step.sv
module cal_hour_step
    import cal_pkg::*;
(
    input  logic             fmt12_i,
    input  hour_op_e         op_i,
    input  logic [1:0]       hr_t_i,
    input  logic [3:0]       hr_u_i,
    input  logic             pm_i,
    input  logic [DAY_W-1:0] day_i,
    output logic [1:0]       hr_t_o,
    output logic [3:0]       hr_u_o,
    output logic             pm_o,
    output logic [DAY_W-1:0] day_o
);
    logic [5:0] hbin;
    logic [5:0] idx;
    logic [5:0] idx_n;
    logic [5:0] hout;

    always_comb begin
        hbin = (6'(hr_t_i) * 6'd10) + 6'(hr_u_i);
        if (fmt12_i) begin
            idx = ((hbin == 6'd12) ? 6'd0 : hbin) + (pm_i ? 6'd12 : 6'd0);
        end else begin
            idx = hbin;
        end

        idx_n = idx;
        day_o = day_i;
        case (op_i)
            HOP_INC: begin
                if (idx == 6'd23) begin
                    idx_n = 6'd0;
                    day_o = (day_i == DAY_MAX) ? day_i : day_i + 1'b1;
                end else begin
                    idx_n = idx + 6'd1;
                end
            end
            HOP_DEC: begin
                if (idx == 6'd0) begin
                    if (fmt12_i) begin
                        idx_n = 6'd23;
                        day_o = (day_i == '0) ? day_i : day_i - 1'b1;
                    end
                end else begin
                    idx_n = idx - 6'd1;
                end
            end
            default: idx_n = idx;
        endcase

        if (fmt12_i) begin
            pm_o = (idx_n >= 6'd12);
            hout = pm_o ? (idx_n - 6'd12) : idx_n;
            if (hout == 6'd0) hout = 6'd12;
        end else begin
            pm_o = 1'b0;
            hout = idx_n;
        end

        if (hout >= 6'd20) begin
            hr_t_o = 2'd2;
            hr_u_o = 4'(hout - 6'd20);
        end else if (hout >= 6'd10) begin
            hr_t_o = 2'd1;
            hr_u_o = 4'(hout - 6'd10);
        end else begin
            hr_t_o = 2'd0;
            hr_u_o = 4'(hout);
        end

        if (op_i == HOP_NONE) begin
            hr_t_o = hr_t_i;
            hr_u_o = hr_u_i;
            pm_o   = pm_i;
        end
    end
endmodule

// File: rtl/cal_day_thr.sv
module cal_day_thr
    import cal_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DAY_W-1:0] day_i,
    input  logic [DAY_W-1:0] thresh_i,
    input  logic             clr_i,
    input  logic             ie_i,
    output logic             flag_o,
    output logic             irq_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (day_i > thresh_i) begin
            flag_d = 1'b1;
        end else if (clr_i) begin
            flag_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;
    assign irq_o  = flag_q & ie_i;
endmodule

// File: rtl/cal_time_core.sv
module cal_time_core
    import cal_pkg::*;
#(
    parameter int RESUME_CLKS = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_i,
    input  logic        init_i,
    input  logic [31:0] load_i,
    input  logic        fmt12_i,
    input  logic        add_hr_i,
    input  logic        sub_hr_i,
    input  logic [8:0]  thresh_i,
    input  logic        thr_ie_i,
    input  logic        thr_clr_i,
    output logic [31:0] time_o,
    output logic        thr_flag_o,
    output logic        thr_irq_o
);
    localparam int HOLD_W = $clog2(RESUME_CLKS + 1);
    localparam int STAGES = 2;

    typedef struct packed {
        cal_time_t         tm;
        logic              init_q;
        logic [HOLD_W-1:0] hold;
        logic              pend_add;
        logic              pend_sub;
    } core_state_t;

    core_state_t st_d, st_q;

    logic       load_edge;
    logic       tick_ok;
    logic       new_add, new_sub, have_new;
    logic       cmd_add, cmd_any, apply;
    hour_op_e   hop;

    logic [STAGES:0] carry;
    logic [2:0]      tens_in  [STAGES];
    logic [3:0]      units_in [STAGES];
    logic [2:0]      tens_out [STAGES];
    logic [3:0]      units_out[STAGES];

    logic [1:0]       hs_hr_t;
    logic [3:0]       hs_hr_u;
    logic             hs_pm;
    logic [DAY_W-1:0] hs_day;

    assign load_edge = st_q.init_q & ~init_i;
    assign tick_ok   = tick_i & ~init_i & ~load_edge & (st_q.hold == '0);

    assign tens_in[0]  = st_q.tm.sc_t;
    assign units_in[0] = st_q.tm.sc_u;
    assign tens_in[1]  = st_q.tm.mn_t;
    assign units_in[1] = st_q.tm.mn_u;
    assign carry[0]    = tick_ok;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_bcd60
            cal_bcd60 u_cnt (
                .inc_i   (carry[g]),
                .tens_i  (tens_in[g]),
                .units_i (units_in[g]),
                .tens_o  (tens_out[g]),
                .units_o (units_out[g]),
                .carry_o (carry[g+1])
            );
        end
    endgenerate

    always_comb begin
        new_add  = add_hr_i & ~init_i & ~load_edge;
        new_sub  = sub_hr_i & ~init_i & ~load_edge & ~add_hr_i;
        have_new = new_add | new_sub;
        cmd_add  = have_new ? new_add : st_q.pend_add;
        cmd_any  = have_new | st_q.pend_add | st_q.pend_sub;
        apply    = cmd_any & ~carry[STAGES] & (have_new | tick_ok);
        if (carry[STAGES])  hop = HOP_INC;
        else if (apply)     hop = cmd_add ? HOP_INC : HOP_DEC;
        else                hop = HOP_NONE;
    end

    cal_hour_step u_hour (
        .fmt12_i (fmt12_i),
        .op_i    (hop),
        .hr_t_i  (st_q.tm.hr_t),
        .hr_u_i  (st_q.tm.hr_u),
        .pm_i    (st_q.tm.pm),
        .day_i   (st_q.tm.day),
        .hr_t_o  (hs_hr_t),
        .hr_u_o  (hs_hr_u),
        .pm_o    (hs_pm),
        .day_o   (hs_day)
    );

    always_comb begin
        st_d        = st_q;
        st_d.init_q = init_i;
        if (st_q.hold != '0) st_d.hold = st_q.hold - 1'b1;

        if (init_i) begin
            st_d.pend_add = 1'b0;
            st_d.pend_sub = 1'b0;
        end else if (load_edge) begin
            st_d.tm       = cal_unpack(load_i, fmt12_i);
            st_d.hold     = HOLD_W'(RESUME_CLKS);
            st_d.pend_add = 1'b0;
            st_d.pend_sub = 1'b0;
        end else begin
            st_d.tm.sc_t = tens_out[0];
            st_d.tm.sc_u = units_out[0];
            st_d.tm.mn_t = tens_out[1];
            st_d.tm.mn_u = units_out[1];
            st_d.tm.hr_t = hs_hr_t;
            st_d.tm.hr_u = hs_hr_u;
            st_d.tm.pm   = hs_pm;
            st_d.tm.day  = hs_day;
            if (carry[STAGES] && cmd_any) begin
                st_d.pend_add = cmd_add;
                st_d.pend_sub = ~cmd_add;
            end else if (apply) begin
                st_d.pend_add = 1'b0;
                st_d.pend_sub = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign time_o = cal_pack(st_q.tm);

    cal_day_thr u_thr (
        .clk      (clk),
        .rst_n    (rst_n),
        .day_i    (st_q.tm.day),
        .thresh_i (thresh_i),
        .clr_i    (thr_clr_i),
        .ie_i     (thr_ie_i),
        .flag_o   (thr_flag_o),
        .irq_o    (thr_irq_o)
    );
endmodule

// File: rtl/cal_time_core_chk.sv
module cal_time_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tick_i,
    input logic        init_i,
    input logic        fmt12_i,
    input logic        add_hr_i,
    input logic        sub_hr_i,
    input logic        thr_clr_i,
    input logic [31:0] time_o,
    input logic        thr_flag_o,
    input logic        thr_irq_o
);
    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (time_o[15] == 1'b0) && (time_o[7] == 1'b0));

    // R5
    bcd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (time_o[3:0] <= 4'd9) && (time_o[6:4] <= 3'd5) &&
        (time_o[11:8] <= 4'd9) && (time_o[14:12] <= 3'd5));

    // R3
    init_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> $stable(time_o));

    // R12
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_flag_o && !thr_clr_i) |=> thr_flag_o);

    // R12
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !thr_flag_o |-> !thr_irq_o);

    // R9
    sub_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fmt12_i && !init_i && !$past(init_i) && sub_hr_i && !add_hr_i && !tick_i &&
         time_o[21:16] == 6'h00) |=> (time_o[21:16] == 6'h00));
endmodule

bind cal_time_core cal_time_core_chk u_chk (.*);

// File: tb/cal_time_core_tb.sv
module cal_time_core_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        init_i = 1'b0;
    logic [31:0] load_i = '0;
    logic        fmt12_i = 1'b0;
    logic        add_hr_i = 1'b0;
    logic        sub_hr_i = 1'b0;
    logic [8:0]  thresh_i = 9'h1FF;
    logic        thr_ie_i = 1'b0;
    logic        thr_clr_i = 1'b0;
    logic [31:0] time_o;
    logic        thr_flag_o;
    logic        thr_irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cal_time_core u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .init_i(init_i), .load_i(load_i),
        .fmt12_i(fmt12_i), .add_hr_i(add_hr_i), .sub_hr_i(sub_hr_i), .thresh_i(thresh_i),
        .thr_ie_i(thr_ie_i), .thr_clr_i(thr_clr_i), .time_o(time_o),
        .thr_flag_o(thr_flag_o), .thr_irq_o(thr_irq_o)
    );

    function automatic logic [31:0] mk(logic [8:0] day, logic pm, logic [7:0] hh,
                                       logic [7:0] mm, logic [7:0] ss);
        return {day, pm, hh[5:0], 1'b0, mm[6:0], 1'b0, ss[6:0]};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(logic [31:0] w);
        @(negedge clk); init_i = 1'b1; load_i = w;
        @(negedge clk); init_i = 1'b0;
        @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic tick();
        tick_i = 1'b1; @(negedge clk); tick_i = 1'b0;
    endtask

    task automatic add_hr();
        add_hr_i = 1'b1; @(negedge clk); add_hr_i = 1'b0;
    endtask

    task automatic sub_hr();
        sub_hr_i = 1'b1; @(negedge clk); sub_hr_i = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 time", time_o, 32'h0);
        check("R1 flag", {31'b0, thr_flag_o}, 32'h0);
        check("R1 irq", {31'b0, thr_irq_o}, 32'h0);
    endtask

    task automatic t_layout();
        fmt12_i = 1'b0;
        load(mk(9'd7, 1'b0, 8'h14, 8'h37, 8'h25) | 32'h0000_8080);
        check("R2 reserved bits", time_o, mk(9'd7, 1'b0, 8'h14, 8'h37, 8'h25));
        load(mk(9'd7, 1'b1, 8'h14, 8'h37, 8'h25));
        check("R4 pm forced low in 24h", time_o, mk(9'd7, 1'b0, 8'h14, 8'h37, 8'h25));
    endtask

    task automatic t_init_hold();
        load(mk(9'd1, 1'b0, 8'h08, 8'h00, 8'h10));
        @(negedge clk); init_i = 1'b1; load_i = mk(9'd2, 1'b0, 8'h09, 8'h00, 8'h00);
        @(negedge clk); tick();
        add_hr();
        check("R3 frozen in init", time_o, mk(9'd1, 1'b0, 8'h08, 8'h00, 8'h10));
        init_i = 1'b0;
        @(negedge clk);
        check("R4 load on exit", time_o, mk(9'd2, 1'b0, 8'h09, 8'h00, 8'h00));
        tick();
        check("R4 tick in settle ignored", time_o, mk(9'd2, 1'b0, 8'h09, 8'h00, 8'h00));
        repeat (3) @(negedge clk);
        tick();
        check("R4 counting resumes", time_o, mk(9'd2, 1'b0, 8'h09, 8'h00, 8'h01));
    endtask

    task automatic t_roll24();
        fmt12_i = 1'b0;
        load(mk(9'd5, 1'b0, 8'h10, 8'h14, 8'h59));
        tick();
        check("R5 second carry", time_o, mk(9'd5, 1'b0, 8'h10, 8'h15, 8'h00));
        load(mk(9'd5, 1'b0, 8'h10, 8'h59, 8'h59));
        tick();
        check("R5 minute carry", time_o, mk(9'd5, 1'b0, 8'h11, 8'h00, 8'h00));
        load(mk(9'd5, 1'b0, 8'h23, 8'h59, 8'h59));
        tick();
        check("R6 midnight", time_o, mk(9'd6, 1'b0, 8'h00, 8'h00, 8'h00));
    endtask

    task automatic t_roll12();
        fmt12_i = 1'b1;
        load(mk(9'd2, 1'b0, 8'h11, 8'h59, 8'h59));
        tick();
        check("R7 noon", time_o, mk(9'd2, 1'b1, 8'h12, 8'h00, 8'h00));
        load(mk(9'd2, 1'b1, 8'h11, 8'h59, 8'h59));
        tick();
        check("R7 midnight", time_o, mk(9'd3, 1'b0, 8'h12, 8'h00, 8'h00));
        load(mk(9'd2, 1'b1, 8'h12, 8'h59, 8'h59));
        tick();
        check("R7 twelve to one", time_o, mk(9'd2, 1'b1, 8'h01, 8'h00, 8'h00));
    endtask

    task automatic t_add();
        fmt12_i = 1'b0;
        load(mk(9'd4, 1'b0, 8'h10, 8'h20, 8'h30));
        add_hr();
        check("R8 add", time_o, mk(9'd4, 1'b0, 8'h11, 8'h20, 8'h30));
        load(mk(9'd4, 1'b0, 8'h23, 8'h20, 8'h30));
        add_hr();
        check("R8 add over midnight", time_o, mk(9'd5, 1'b0, 8'h00, 8'h20, 8'h30));
        add_hr_i = 1'b1; sub_hr_i = 1'b1; @(negedge clk); add_hr_i = 1'b0; sub_hr_i = 1'b0;
        check("R8 add wins", time_o, mk(9'd5, 1'b0, 8'h01, 8'h20, 8'h30));
        fmt12_i = 1'b1;
        load(mk(9'd3, 1'b1, 8'h11, 8'h05, 8'h06));
        add_hr();
        check("R8 add 11PM", time_o, mk(9'd4, 1'b0, 8'h12, 8'h05, 8'h06));
    endtask

    task automatic t_sub();
        fmt12_i = 1'b0;
        load(mk(9'd4, 1'b0, 8'h10, 8'h00, 8'h00));
        sub_hr();
        check("R9 sub", time_o, mk(9'd4, 1'b0, 8'h09, 8'h00, 8'h00));
        load(mk(9'd4, 1'b0, 8'h00, 8'h30, 8'h00));
        sub_hr();
        check("R9 sub at zero ignored", time_o, mk(9'd4, 1'b0, 8'h00, 8'h30, 8'h00));
        fmt12_i = 1'b1;
        load(mk(9'd3, 1'b0, 8'h12, 8'h05, 8'h06));
        sub_hr();
        check("R9 sub 12AM", time_o, mk(9'd2, 1'b1, 8'h11, 8'h05, 8'h06));
        load(mk(9'd3, 1'b1, 8'h01, 8'h05, 8'h06));
        sub_hr();
        check("R9 sub 1PM", time_o, mk(9'd3, 1'b1, 8'h12, 8'h05, 8'h06));
    endtask

    task automatic t_defer();
        fmt12_i = 1'b0;
        load(mk(9'd8, 1'b0, 8'h05, 8'h59, 8'h59));
        tick_i = 1'b1; add_hr_i = 1'b1; @(negedge clk); tick_i = 1'b0; add_hr_i = 1'b0;
        check("R10 carry first", time_o, mk(9'd8, 1'b0, 8'h06, 8'h00, 8'h00));
        repeat (3) @(negedge clk);
        check("R10 held until tick", time_o, mk(9'd8, 1'b0, 8'h06, 8'h00, 8'h00));
        tick();
        check("R10 applied next second", time_o, mk(9'd8, 1'b0, 8'h07, 8'h00, 8'h01));
        tick();
        check("R10 applied once", time_o, mk(9'd8, 1'b0, 8'h07, 8'h00, 8'h02));
    endtask

    task automatic t_sat();
        fmt12_i = 1'b0;
        load(mk(9'd511, 1'b0, 8'h23, 8'h59, 8'h59));
        tick();
        check("R11 day saturates high", time_o, mk(9'd511, 1'b0, 8'h00, 8'h00, 8'h00));
        fmt12_i = 1'b1;
        load(mk(9'd0, 1'b0, 8'h12, 8'h00, 8'h00));
        sub_hr();
        check("R11 day saturates low", time_o, mk(9'd0, 1'b1, 8'h11, 8'h00, 8'h00));
    endtask

    task automatic t_thr();
        fmt12_i = 1'b0;
        thresh_i = 9'd5;
        load(mk(9'd5, 1'b0, 8'h01, 8'h00, 8'h00));
        check("R12 equal no flag", {31'b0, thr_flag_o}, 32'h0);
        load(mk(9'd6, 1'b0, 8'h01, 8'h00, 8'h00));
        check("R12 flag set", {31'b0, thr_flag_o}, 32'h1);
        check("R12 irq masked", {31'b0, thr_irq_o}, 32'h0);
        thr_ie_i = 1'b1; @(negedge clk);
        check("R12 irq enabled", {31'b0, thr_irq_o}, 32'h1);
        thr_clr_i = 1'b1; @(negedge clk); thr_clr_i = 1'b0; @(negedge clk);
        check("R12 clear while over", {31'b0, thr_flag_o}, 32'h1);
        thresh_i = 9'h1FF; repeat (2) @(negedge clk);
        check("R12 sticky", {31'b0, thr_flag_o}, 32'h1);
        thr_clr_i = 1'b1; @(negedge clk); thr_clr_i = 1'b0; @(negedge clk);
        check("R12 cleared", {31'b0, thr_flag_o}, 32'h0);
        check("R12 irq cleared", {31'b0, thr_irq_o}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_layout();
        t_init_hold();
        t_roll24();
        t_roll12();
        t_add();
        t_sub();
        t_defer();
        t_sat();
        t_thr();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule